// File: doc/BRIEF.md
# Row-Stationary 1D Convolution Processing Element

This block is one processing element of a convolution array. It keeps one or more filter rows resident in a small local weight store. It takes in a stream of activations, one input row or several, and slides a window of the filter width across them. The products are summed locally, and the result is one partial-sum row, emitted one value at a time. One multiply-accumulate (MAC) is done per clock cycle. An accumulator inside the element holds each output value until it is complete, so no intermediate sum leaves the element.

Filter rows are written tap by tap while the element is idle. They stay in place across any number of runs, so a filter row is loaded once and reused. A run is started with a configuration that sets the filter width R, the input row length W, a row count N and one of four modes. The modes are: a single row; several input rows concatenated and run against one filter; several filter rows interleaved over one input row; and several channels, where each channel has its own filter row and input row and all of them are summed into a single output row. An upstream partial sum can be added to each output before it is emitted. A handshake paces this, so that a column of elements can chain their sums.

The controller is a four-state machine. IDLE waits for `start` and latches the configuration (transition IDLE→LOAD). LOAD accepts activations until the configured count has been stored (LOAD→MAC). MAC performs one MAC per cycle until the current output's sum is complete (MAC→EMIT). EMIT adds the upstream partial sum, waiting in EMIT while that sum is not yet offered, and registers the output. It then goes on to the next output (EMIT→MAC), or ends the run after the last one (EMIT→IDLE).

Top module: `rs_row_pe`

## Requirements
- R1: After reset `out_valid`, `done`, `busy`, `act_ready` and `psum_in_ready` are all 0, and every weight tap reads as 0.
- R2: While idle, `wt_we` writes `wt_data` into filter slot `wt_slot`, tap `wt_tap` (tap 0 is the leftmost weight). Weights are held unchanged across any number of runs until they are written again.
- R3: Weight writes presented while `busy` is 1 are ignored: they do not change the results of the current run or of later runs.
- R4: A `start` seen while idle latches `cfg_mode`, `cfg_taps` (R, 1..5), `cfg_len` (W, R..16), `cfg_rows` (N, 1..4) and `cfg_use_psum`. The mode encoding is 0 = single row, 1 = concatenated input rows, 2 = interleaved filters, 3 = channel accumulation. `act_ready` is then 1 until exactly W activations (modes 0 and 2) or N·W activations (modes 1 and 3) have been taken. Activations are taken in row order, each row left to right.
- R5: In mode 0 the run emits E = W−R+1 values. Output e equals the sum over k of w[0][k]·x[e+k], in two's-complement arithmetic, and outputs come in increasing e.
- R6: In mode 1 the N input rows are each convolved with slot 0. All E outputs of row 0 come first, then all of row 1, and so on, for N·E values.
- R7: In mode 2 the single input row is convolved with slots 0..N−1. For each window position e, the outputs of slot 0..N−1 come in slot order, for N·E values.
- R8: In mode 3 input row c pairs with slot c. The run emits E values, and output e equals the sum over c and k of w[c][k]·x_c[e+k].
- R9: With `cfg_use_psum` = 1, each output waits until `psum_in_valid` is 1, with `psum_in_ready` = 1 during the wait, and the value emitted is the convolution result plus `psum_in`. With `cfg_use_psum` = 0, `psum_in_ready` stays 0 and `psum_in` has no effect.
- R10: One MAC is done per cycle. `out_valid` is a one-cycle pulse. With no upstream stall, consecutive outputs are R+1 cycles apart (R·N+1 in mode 3).
- R11: `done` is 1 in the same cycle as the final `out_valid` of a run, with `busy` already 0. A `start` while busy is ignored.
- R12: The edge shapes work: R = W yields exactly one output per group, and R = 1 yields W outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight tap write strobe (honoured only when idle) |
| wt_slot | input | 2 | Filter slot written |
| wt_tap | input | 3 | Tap index within the slot |
| wt_data | input | 8 | Signed weight value |
| start | input | 1 | Begin a run, configuration taken from the cfg inputs |
| cfg_mode | input | 2 | Mode: 0 single, 1 concatenated rows, 2 interleaved filters, 3 channel sum |
| cfg_taps | input | 3 | Filter width R |
| cfg_len | input | 5 | Input row length W |
| cfg_rows | input | 3 | Row, filter or channel count N |
| cfg_use_psum | input | 1 | Add the upstream partial sum to every output |
| act_valid | input | 1 | Activation offered |
| act_data | input | 8 | Signed activation value |
| act_ready | output | 1 | Element is taking activations |
| psum_in_valid | input | 1 | Upstream partial sum offered |
| psum_in | input | 24 | Signed upstream partial sum |
| psum_in_ready | output | 1 | Element consumes the upstream sum this cycle if it is valid |
| out_valid | output | 1 | Output value present (one-cycle pulse) |
| out_psum | output | 24 | Signed output partial sum |
| done | output | 1 | Final output of the run |
| busy | output | 1 | A run is in progress |

## Verification
On every cycle the assertions check the local properties of the machine. Each output is a single-cycle pulse, and no output appears while an upstream sum is awaited. `done` only comes with an output and after `busy` has dropped. The accumulator is clear at the start of each output, and every configuration taken at a start is legal. Only the bench's scenarios can show the arithmetic and the ordering of each mode against a model: concatenated rows, interleaved filters and summed channels under random shapes. The same scenarios show the output spacing that follows from one MAC per cycle, the exact activation count, and that weight writes and restarts made during a run leave the results untouched.

// File: rtl/rs_pe_pkg.sv
package rs_pe_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_FMAP_CAT = 2'd1,
        MODE_FILT_ILV = 2'd2,
        MODE_CHAN_ACC = 2'd3
    } rs_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MAC  = 2'd2,
        ST_EMIT = 2'd3
    } rs_state_e;

endpackage

// File: rtl/rs_weight_rf.sv
module rs_weight_rf #(
    parameter int DW    = 8,
    parameter int MAX_R = 5,
    parameter int NSLOT = 4,
    localparam int TW   = (MAX_R > 1) ? $clog2(MAX_R) : 1,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [SLW-1:0] wr_slot,
    input  logic [TW-1:0]  wr_tap,
    input  logic [DW-1:0]  wr_data,
    input  logic [SLW-1:0] rd_slot,
    input  logic [TW-1:0]  rd_tap,
    output logic [DW-1:0]  rd_data
);

    logic [DW-1:0] taps_mem [NSLOT][MAX_R];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                for (int t = 0; t < MAX_R; t++) begin
                    taps_mem[s][t] <= '0;
                end
            end
        end else if (wr_en && int'(wr_tap) < MAX_R && int'(wr_slot) < NSLOT) begin
            taps_mem[wr_slot][wr_tap] <= wr_data;
        end
    end

    assign rd_data = taps_mem[rd_slot][rd_tap];

endmodule

// File: rtl/rs_fmap_rf.sv
module rs_fmap_rf #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] row_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = row_mem[rd_addr];

endmodule

// File: rtl/rs_mac_unit.sv
module rs_mac_unit #(
    parameter int DW = 8,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] wt,
    input  logic [DW-1:0] act,
    output logic [PW-1:0] acc
);

    logic signed [2*DW-1:0] prod;
    logic        [PW-1:0]   prod_ext;

    assign prod     = $signed(wt) * $signed(act);
    assign prod_ext = {{(PW-2*DW){prod[2*DW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

    // R5: each output's sum starts from zero
    a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

endmodule

// File: rtl/rs_pe_ctrl.sv
module rs_pe_ctrl
    import rs_pe_pkg::*;
#(
    parameter int PW    = 24,
    parameter int MAX_R = 5,
    parameter int MAX_W = 16,
    parameter int NSLOT = 4,
    localparam int TW   = (MAX_R > 1) ? $clog2(MAX_R) : 1,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int RW   = $clog2(MAX_R + 1),
    localparam int LW   = $clog2(MAX_W + 1),
    localparam int NW   = $clog2(NSLOT + 1),
    localparam int XA   = $clog2(NSLOT * MAX_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     cfg_mode,
    input  logic [RW-1:0]  cfg_taps,
    input  logic [LW-1:0]  cfg_len,
    input  logic [NW-1:0]  cfg_rows,
    input  logic           cfg_use_psum,
    input  logic           act_valid,
    input  logic           psum_in_valid,
    input  logic [PW-1:0]  psum_in,
    input  logic [PW-1:0]  acc,
    output logic           act_ready,
    output logic           psum_in_ready,
    output logic           busy,
    output logic           x_we,
    output logic [XA-1:0]  x_waddr,
    output logic [XA-1:0]  x_raddr,
    output logic [SLW-1:0] w_rslot,
    output logic [TW-1:0]  w_rtap,
    output logic           mac_en,
    output logic           mac_clr,
    output logic           out_valid,
    output logic [PW-1:0]  out_psum,
    output logic           done
);

    rs_state_e state_q, state_d;

    rs_mode_e       mode_q;
    logic [RW-1:0]  taps_q;
    logic [LW-1:0]  len_q;
    logic [LW-1:0]  last_pos_q;
    logic [NW-1:0]  rows_q;
    logic           usep_q;

    logic [TW-1:0]  tap_q;
    logic [SLW-1:0] grp_q;
    logic [LW-1:0]  pos_q;
    logic [SLW-1:0] ld_row_q;
    logic [LW-1:0]  ld_col_q;

    logic multi_rows, multi_filt;
    logic tap_end, grp_end, pos_end, col_end, row_end;
    logic load_end, mac_end, emit_ok, emit_end;
    logic [SLW-1:0] x_row;

    assign multi_rows = (mode_q == MODE_FMAP_CAT) || (mode_q == MODE_CHAN_ACC);
    assign multi_filt = (mode_q == MODE_FILT_ILV) || (mode_q == MODE_CHAN_ACC);

    assign tap_end  = (RW'(tap_q) == taps_q - RW'(1));
    assign grp_end  = (NW'(grp_q) == rows_q - NW'(1));
    assign pos_end  = (pos_q == last_pos_q);
    assign col_end  = (ld_col_q == len_q - LW'(1));
    assign row_end  = (NW'(ld_row_q) == rows_q - NW'(1));

    assign load_end = col_end && (!multi_rows || row_end);
    assign mac_end  = tap_end && ((mode_q != MODE_CHAN_ACC) || grp_end);
    assign emit_ok  = !usep_q || psum_in_valid;
    assign emit_end = pos_end &&
                      (((mode_q == MODE_FMAP_CAT) || (mode_q == MODE_FILT_ILV)) ? grp_end : 1'b1);

    // register-file addressing
    assign x_row   = multi_rows ? grp_q : '0;
    assign x_raddr = XA'(x_row) * XA'(MAX_W) + XA'(pos_q) + XA'(tap_q);
    assign x_waddr = XA'(ld_row_q) * XA'(MAX_W) + XA'(ld_col_q);
    assign w_rslot = multi_filt ? grp_q : '0;
    assign w_rtap  = tap_q;

    assign busy          = (state_q != ST_IDLE);
    assign act_ready     = (state_q == ST_LOAD);
    assign x_we          = (state_q == ST_LOAD) && act_valid;
    assign psum_in_ready = (state_q == ST_EMIT) && usep_q;
    assign mac_en        = (state_q == ST_MAC);
    assign mac_clr       = (state_q == ST_IDLE) || ((state_q == ST_EMIT) && emit_ok);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                  state_d = ST_LOAD;
            ST_LOAD: if (act_valid && load_end)  state_d = ST_MAC;
            ST_MAC:  if (mac_end)                state_d = ST_EMIT;
            ST_EMIT: if (emit_ok)                state_d = emit_end ? ST_IDLE : ST_MAC;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // configuration, counters and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_SINGLE;
            taps_q     <= RW'(1);
            len_q      <= LW'(1);
            last_pos_q <= '0;
            rows_q     <= NW'(1);
            usep_q     <= 1'b0;
            tap_q      <= '0;
            grp_q      <= '0;
            pos_q      <= '0;
            ld_row_q   <= '0;
            ld_col_q   <= '0;
            out_valid  <= 1'b0;
            out_psum   <= '0;
            done       <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q     <= rs_mode_e'(cfg_mode);
                        taps_q     <= cfg_taps;
                        len_q      <= cfg_len;
                        last_pos_q <= cfg_len - LW'(cfg_taps);
                        rows_q     <= cfg_rows;
                        usep_q     <= cfg_use_psum;
                        tap_q      <= '0;
                        grp_q      <= '0;
                        pos_q      <= '0;
                        ld_row_q   <= '0;
                        ld_col_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (act_valid) begin
                        if (col_end) begin
                            ld_col_q <= '0;
                            ld_row_q <= ld_row_q + 1'b1;
                        end else begin
                            ld_col_q <= ld_col_q + 1'b1;
                        end
                    end
                end
                ST_MAC: begin
                    if (tap_end) begin
                        tap_q <= '0;
                        if (mode_q == MODE_CHAN_ACC) begin
                            grp_q <= grp_end ? '0 : grp_q + 1'b1;
                        end
                    end else begin
                        tap_q <= tap_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (emit_ok) begin
                        out_valid <= 1'b1;
                        out_psum  <= acc + (usep_q ? psum_in : '0);
                        done      <= emit_end;
                        unique case (mode_q)
                            MODE_FMAP_CAT: begin
                                if (pos_end) begin
                                    pos_q <= '0;
                                    grp_q <= grp_q + 1'b1;
                                end else begin
                                    pos_q <= pos_q + 1'b1;
                                end
                            end
                            MODE_FILT_ILV: begin
                                if (grp_end) begin
                                    grp_q <= '0;
                                    pos_q <= pos_q + 1'b1;
                                end else begin
                                    grp_q <= grp_q + 1'b1;
                                end
                            end
                            MODE_SINGLE, MODE_CHAN_ACC: begin
                                pos_q <= pos_q + 1'b1;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // R10: an output is a single-cycle pulse
    a_r10_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R11: done only with the final output, after busy has fallen
    a_r11_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && !busy));

    // R9: no output while the upstream sum is awaited
    a_r9_wait_psum: assert property (@(posedge clk) disable iff (!rst_n)
        (psum_in_ready && !psum_in_valid) |=> !out_valid);

    // R4: a configuration taken at start is within range
    a_r4_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |->
            (cfg_taps != '0 && int'(cfg_taps) <= MAX_R &&
             cfg_len >= LW'(cfg_taps) && int'(cfg_len) <= MAX_W &&
             cfg_rows != '0 && int'(cfg_rows) <= NSLOT));

endmodule

// File: rtl/rs_row_pe.sv
module rs_row_pe #(
    parameter int DW    = 8,
    parameter int PW    = 24,
    parameter int MAX_R = 5,
    parameter int MAX_W = 16,
    parameter int NSLOT = 4,
    localparam int TW   = (MAX_R > 1) ? $clog2(MAX_R) : 1,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int RW   = $clog2(MAX_R + 1),
    localparam int LW   = $clog2(MAX_W + 1),
    localparam int NW   = $clog2(NSLOT + 1),
    localparam int XA   = $clog2(NSLOT * MAX_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wt_we,
    input  logic [SLW-1:0] wt_slot,
    input  logic [TW-1:0]  wt_tap,
    input  logic [DW-1:0]  wt_data,
    input  logic           start,
    input  logic [1:0]     cfg_mode,
    input  logic [RW-1:0]  cfg_taps,
    input  logic [LW-1:0]  cfg_len,
    input  logic [NW-1:0]  cfg_rows,
    input  logic           cfg_use_psum,
    input  logic           act_valid,
    input  logic [DW-1:0]  act_data,
    output logic           act_ready,
    input  logic           psum_in_valid,
    input  logic [PW-1:0]  psum_in,
    output logic           psum_in_ready,
    output logic           out_valid,
    output logic [PW-1:0]  out_psum,
    output logic           done,
    output logic           busy
);

    logic           x_we;
    logic [XA-1:0]  x_waddr, x_raddr;
    logic [SLW-1:0] w_rslot;
    logic [TW-1:0]  w_rtap;
    logic [DW-1:0]  w_val, x_val;
    logic           mac_en, mac_clr;
    logic [PW-1:0]  acc;
    logic           wt_wr_ok;

    // weights change only between runs
    assign wt_wr_ok = wt_we && !busy;

    rs_weight_rf #(.DW(DW), .MAX_R(MAX_R), .NSLOT(NSLOT)) u_wrf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wt_wr_ok),
        .wr_slot (wt_slot),
        .wr_tap  (wt_tap),
        .wr_data (wt_data),
        .rd_slot (w_rslot),
        .rd_tap  (w_rtap),
        .rd_data (w_val)
    );

    rs_fmap_rf #(.DW(DW), .DEPTH(NSLOT * MAX_W)) u_xrf (
        .clk     (clk),
        .wr_en   (x_we),
        .wr_addr (x_waddr),
        .wr_data (act_data),
        .rd_addr (x_raddr),
        .rd_data (x_val)
    );

    rs_mac_unit #(.DW(DW), .PW(PW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mac_clr),
        .en    (mac_en),
        .wt    (w_val),
        .act   (x_val),
        .acc   (acc)
    );

    rs_pe_ctrl #(.PW(PW), .MAX_R(MAX_R), .MAX_W(MAX_W), .NSLOT(NSLOT)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_mode      (cfg_mode),
        .cfg_taps      (cfg_taps),
        .cfg_len       (cfg_len),
        .cfg_rows      (cfg_rows),
        .cfg_use_psum  (cfg_use_psum),
        .act_valid     (act_valid),
        .psum_in_valid (psum_in_valid),
        .psum_in       (psum_in),
        .acc           (acc),
        .act_ready     (act_ready),
        .psum_in_ready (psum_in_ready),
        .busy          (busy),
        .x_we          (x_we),
        .x_waddr       (x_waddr),
        .x_raddr       (x_raddr),
        .w_rslot       (w_rslot),
        .w_rtap        (w_rtap),
        .mac_en        (mac_en),
        .mac_clr       (mac_clr),
        .out_valid     (out_valid),
        .out_psum      (out_psum),
        .done          (done)
    );

endmodule

// File: tb/rs_row_pe_test.sv
module rs_row_pe_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSL = 4;
    localparam int MR  = 5;
    localparam int MW  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0;
    logic [1:0]  wt_slot = '0;
    logic [2:0]  wt_tap = '0;
    logic [7:0]  wt_data = '0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [2:0]  cfg_taps = 3'd1;
    logic [4:0]  cfg_len = 5'd1;
    logic [2:0]  cfg_rows = 3'd1;
    logic        cfg_use_psum = 1'b0;
    logic        act_valid = 1'b0;
    logic [7:0]  act_data = '0;
    logic        act_ready;
    logic        psum_in_valid = 1'b0;
    logic [23:0] psum_in = '0;
    logic        psum_in_ready;
    logic        out_valid;
    logic [23:0] out_psum;
    logic        done;
    logic        busy;

    rs_row_pe uut (
        .clk(clk), .rst_n(rst_n),
        .wt_we(wt_we), .wt_slot(wt_slot), .wt_tap(wt_tap), .wt_data(wt_data),
        .start(start), .cfg_mode(cfg_mode), .cfg_taps(cfg_taps), .cfg_len(cfg_len),
        .cfg_rows(cfg_rows), .cfg_use_psum(cfg_use_psum),
        .act_valid(act_valid), .act_data(act_data), .act_ready(act_ready),
        .psum_in_valid(psum_in_valid), .psum_in(psum_in), .psum_in_ready(psum_in_ready),
        .out_valid(out_valid), .out_psum(out_psum), .done(done), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    int wm [NSL][MR];
    int xm [NSL*MW];
    int pq [128];
    int ov [128];
    int ot [128];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string mode_tag(input int mode);
        case (mode)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int out_count(input int mode, input int r, input int w, input int n);
        int e = w - r + 1;
        return (mode == 1 || mode == 2) ? n * e : e;
    endfunction

    function automatic int ref_val(input int mode, input int r, input int w, input int n, input int j);
        int e_cnt = w - r + 1;
        int s = 0;
        case (mode)
            0: for (int k = 0; k < r; k++) s += wm[0][k] * xm[j + k];
            1: for (int k = 0; k < r; k++) s += wm[0][k] * xm[(j / e_cnt) * w + (j % e_cnt) + k];
            2: for (int k = 0; k < r; k++) s += wm[j % n][k] * xm[(j / n) + k];
            default:
                for (int c = 0; c < n; c++)
                    for (int k = 0; k < r; k++) s += wm[c][k] * xm[c * w + j + k];
        endcase
        return s;
    endfunction

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic write_tap(input int s, input int t, input int v);
        @(negedge clk);
        wt_we = 1'b1; wt_slot = 2'(s); wt_tap = 3'(t); wt_data = 8'(v);
        @(negedge clk);
        wt_we = 1'b0;
        wm[s][t] = v;
    endtask

    task automatic fill_acts(input int cnt);
        for (int i = 0; i < cnt; i++) xm[i] = rnd8();
    endtask

    // One run; xm must hold the activations in stream order.
    task automatic run(input int mode, input int r, input int w, input int n, input bit usep,
                       input bit poke_wt, input bit poke_start);
        int nacts = (mode == 1 || mode == 3) ? n * w : w;
        int nexp  = out_count(mode, r, w, n);
        int idx = 0, np = 0, nout = 0, guard = 0;
        bit last_done = 0, got_done = 0;
        int extra_ready = 0, bad_pready = 0, busy_at_done = 0;
        int gap = (mode == 3) ? r * n + 1 : r + 1;
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_taps = 3'(r); cfg_len = 5'(w); cfg_rows = 3'(n);
        cfg_use_psum = usep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(act_ready == 1'b1 && busy == 1'b1, "R4 ready after start", int'(act_ready), 1);
        while (!got_done && guard < 5000) begin
            guard++;
            wt_we = 1'b0; start = 1'b0;
            if (out_valid) begin
                ov[nout] = int'($signed(out_psum));
                ot[nout] = cyc;
                last_done = done;
                nout++;
                if (done) begin
                    got_done = 1;
                    if (busy) busy_at_done++;
                end
            end else if (done) begin
                last_done = 0;
            end
            if (got_done) begin
                act_valid = 1'b0; psum_in_valid = 1'b0;
                break;
            end
            if (idx == nacts && act_ready) extra_ready++;
            if (!usep && psum_in_ready) bad_pready++;
            if (idx < nacts) begin
                act_valid = ($urandom_range(3) != 0);
                act_data  = 8'(xm[idx]);
                if (act_ready && act_valid) idx++;
            end else begin
                act_valid = ($urandom_range(1) == 1);
                act_data  = 8'($urandom);
            end
            psum_in_valid = ($urandom_range(1) == 1);
            begin
                int pv = int'($urandom_range(2000000)) - 1000000;
                psum_in = 24'(pv);
                if (psum_in_ready && psum_in_valid) begin
                    pq[np] = pv;
                    np++;
                end
            end
            if (poke_wt && busy) begin
                wt_we = 1'b1; wt_slot = 2'($urandom); wt_tap = 3'($urandom_range(MR - 1));
                wt_data = 8'($urandom);
            end
            if (poke_start && busy && $urandom_range(5) == 0) begin
                start = 1'b1;
                cfg_mode = 2'($urandom); cfg_taps = 3'd1; cfg_len = 5'd1; cfg_rows = 3'd1;
            end
            @(negedge clk);
        end
        wt_we = 1'b0; start = 1'b0; act_valid = 1'b0; psum_in_valid = 1'b0;
        chk(got_done, "R11 run completes with done", int'(got_done), 1);
        chk(nout == nexp, {mode_tag(mode), " output count"}, nout, nexp);
        chk(extra_ready == 0, "R4 activation count exact", extra_ready, 0);
        chk(last_done && busy_at_done == 0, "R11 done with last output, busy low",
            int'(last_done), 1);
        if (usep) chk(np >= nout, "R9 upstream sums consumed", np, nout);
        else      chk(bad_pready == 0, "R9 psum_in_ready stays low when unused", bad_pready, 0);
        for (int j = 0; j < nout && j < nexp; j++) begin
            int ev = ref_val(mode, r, w, n, j) + ((usep && j < np) ? pq[j] : 0);
            chk(ov[j] == ev, usep ? {mode_tag(mode), "/R9 value"} : {mode_tag(mode), " value"},
                ov[j], ev);
        end
        if (!usep) begin
            int bad = 0;
            for (int j = 1; j < nout; j++) if (ot[j] - ot[j-1] != gap) bad++;
            chk(bad == 0, "R10 output spacing", (nout > 1) ? ot[1] - ot[0] : gap, gap);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1D0C));
        for (int s = 0; s < NSL; s++) for (int t = 0; t < MR; t++) wm[s][t] = 0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !done && !busy && !act_ready && !psum_in_ready,
            "R1 outputs idle under reset", int'(out_valid | done | busy | act_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !act_ready && !out_valid, "R1 idle after reset", int'(busy), 0);

        // R1: all weights zero after reset -> zero outputs
        fill_acts(8);
        run(0, 3, 8, 1, 0, 0, 0);

        // R5/R2: directed single-row case
        write_tap(0, 0, 1); write_tap(0, 1, 2); write_tap(0, 2, 3);
        for (int i = 0; i < 5; i++) xm[i] = i + 1;
        run(0, 3, 5, 1, 0, 0, 0);
        chk(ov[0] == 14 && ov[1] == 20 && ov[2] == 26, "R5 directed 1,2,3 * 1..5", ov[0], 14);

        // R2: load all slots once, reuse across runs
        for (int s = 0; s < NSL; s++) for (int t = 0; t < MR; t++) write_tap(s, t, rnd8());
        fill_acts(MW);
        run(0, 4, 12, 1, 0, 0, 0);
        run(0, 4, 12, 1, 0, 0, 0);

        // R12: edge shapes
        fill_acts(NSL * MW); run(0, 5, 5, 1, 0, 0, 0);
        fill_acts(NSL * MW); run(0, 1, 16, 1, 0, 0, 0);
        fill_acts(NSL * MW); run(1, 5, 5, 4, 0, 0, 0);
        fill_acts(NSL * MW); run(2, 1, 16, 3, 0, 0, 0);

        // R6, R7, R8 directed
        fill_acts(NSL * MW); run(1, 3, 7, 2, 0, 0, 0);
        fill_acts(NSL * MW); run(2, 3, 9, 4, 0, 0, 0);
        fill_acts(NSL * MW); run(3, 3, 10, 3, 0, 0, 0);

        // R9: upstream sum added
        fill_acts(NSL * MW); run(0, 3, 9, 1, 1, 0, 0);
        fill_acts(NSL * MW); run(3, 2, 6, 2, 1, 0, 0);

        // R3: weight writes during a run, then a run proving weights unchanged
        fill_acts(NSL * MW); run(2, 5, 14, 4, 0, 1, 0);
        fill_acts(NSL * MW); run(3, 5, 11, 4, 0, 0, 0);

        // R11: start pulses during a run are ignored
        fill_acts(NSL * MW); run(1, 2, 9, 3, 0, 0, 1);

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int m = int'($urandom_range(3));
            int r = 1 + int'($urandom_range(MR - 1));
            int w = r + int'($urandom_range(MW - r));
            int n = 1 + int'($urandom_range(NSL - 1));
            if ($urandom_range(4) == 0) write_tap(int'($urandom_range(NSL - 1)),
                                                  int'($urandom_range(MR - 1)), rnd8());
            fill_acts(NSL * MW);
            run(m, r, w, n, bit'($urandom_range(1)), bit'($urandom_range(1)),
                bit'($urandom_range(1)));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule